// File: doc/BRIEF.md
# PWM Channel with Dead-Time, Override and Fault Forcing

This block is one pulse-width modulation channel. A selected tick enable drives a 16-bit counter that runs either as a sawtooth (edge-aligned) or as a triangle (center-aligned). A compare stage turns the counter into a raw waveform, and the compare can read either the channel's own counter or a shared master counter. A dead-time stage splits the raw waveform into a complementary high-side and low-side pair. An override stage can replace either output with a constant. A fault stage has the final say over the pins. It acts combinationally on the fault input and can drive each pin to 0 or 1, or release it to high impedance.

Three state machines carry the behaviour. The counter machine has the states C_UP and C_DOWN. In center mode, C_UP goes to C_DOWN when the count reaches the active period, and C_DOWN goes to C_UP when the count reaches zero. In edge mode the machine stays in C_UP and wraps the count to zero. Each of the two dead-time machines has the states D_LOW, D_WAIT and D_HIGH. D_LOW goes to D_WAIT when its target rises and the delay is nonzero, or straight to D_HIGH when the delay is zero. D_WAIT goes to D_HIGH when the delay has counted out. D_WAIT and D_HIGH both fall back to D_LOW as soon as the target drops. The fault machine has the states F_OK and F_TRIP. F_OK goes to F_TRIP on a high fault input. F_TRIP returns to F_OK only on a clear strobe written while the fault input is low.

Software writes registers through a one-cycle parallel strobe. Addresses:

| Address | Content |
|---------|---------|
| 0 | configuration |
| 1 | period |
| 2 | duty |
| 3 | high-side delay |
| 4 | low-side delay |
| 5 | override |
| 6 | fault clear |

Top module: `pwm_chan_prot`

## Requirements
- R1: While reset is held, cnt_out is 0, pwm_hi and pwm_lo are 0, oe_hi and oe_lo are 1, and no fault is active.
- R2: In edge mode (configuration bit 2 = 0) with active period P > 0, the counter counts 0,1,…,P and then returns to 0, so one period lasts P+1 ticks.
- R3: In center mode (configuration bit 2 = 1) with period P > 0, the counter rises from 0 to P and then falls back to 0, so one cycle lasts 2P ticks.
- R4: Configuration bits [1:0] select the tick. Code 0 ticks every clock, and code k (1 to 3) uses tick_div[k-1]. The counter holds whenever the selected tick is low, and ticks on unselected sources have no effect.
- R5: The raw waveform is high while the compared count is below the active duty. The compared count is cnt_out when configuration bit 3 = 0 and master_cnt when it is 1. With zero delays, pwm_hi follows the raw waveform one clock later and pwm_lo follows its inverse one clock later.
- R6: Period and duty writes take effect only at the start of a period. That is the edge-mode wrap to 0, the center-mode turn at 0, or any tick while the active period is 0.
- R7: pwm_hi rises a number of ticks after the raw rise equal to the high-side delay (address 3, 12 bits). pwm_lo rises a number of ticks after the raw fall equal to the low-side delay (address 4). Each output falls one clock after its own target falls, and the two dead-time outputs are never high together.
- R8: Override register (address 5): bit 0 enables high-side override with value bit 1, and bit 2 enables low-side override with value bit 3.
- R9: While a fault is active, each pin follows its 2-bit code. The high-side code is configuration [5:4] and the low-side code is [7:6]. Code 00 drives 0, code 01 drives 1, and code 1x releases the pin (output enable 0). This takes effect in the same cycle as the fault input rises and overrides the override stage.
- R10: A fault stays active after fault_in falls. A write of 1 in bit 0 to address 6 clears it only if fault_in is low at that clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| tick_div | input | 3 | divided tick enables for sources 1 to 3 |
| master_cnt | input | 16 | shared master counter value |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | register address |
| wr_data | input | 16 | register write data |
| fault_in | input | 1 | active-high fault request |
| cnt_out | output | 16 | channel counter value |
| pwm_hi | output | 1 | high-side output data |
| pwm_lo | output | 1 | low-side output data |
| oe_hi | output | 1 | high-side output enable (0 means high impedance) |
| oe_lo | output | 1 | low-side output enable (0 means high impedance) |

## Verification
An active override and a rising fault can fall in the same cycle. The bench first forces the high side to 1 through the override register. It then raises fault_in between clock edges and reads the pins before the next edge, expecting the fault code's value rather than the override value. A fault clear can also coincide with a still-high fault input. The bench writes the clear strobe while fault_in is high and expects the pins to stay forced. Only a later clear, written with fault_in low, may release them.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [0:0] {
        C_UP,
        C_DOWN
    } cnt_st_t;

    typedef enum logic [1:0] {
        D_LOW,
        D_WAIT,
        D_HIGH
    } dt_st_t;

    typedef enum logic [0:0] {
        F_OK,
        F_TRIP
    } flt_st_t;

endpackage

// File: rtl/pwm_cnt.sv
module pwm_cnt
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          center,
    input  logic [CW-1:0] per_sh,
    input  logic [CW-1:0] duty_sh,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] per_act,
    output logic [CW-1:0] duty_act
);

    cnt_st_t       st, st_n;
    logic [CW-1:0] cnt_n;
    logic          load;

    // next-state and next-count
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        load  = 1'b0;
        if (tick) begin
            if (per_act == '0) begin
                st_n  = C_UP;
                cnt_n = '0;
                load  = 1'b1;
            end else if (!center) begin
                st_n = C_UP;
                if (cnt >= per_act) begin
                    cnt_n = '0;
                    load  = 1'b1;
                end else begin
                    cnt_n = cnt + CW'(1);
                end
            end else begin
                unique case (st)
                    C_UP: begin
                        if (cnt >= per_act) begin
                            st_n  = C_DOWN;
                            cnt_n = cnt - CW'(1);
                        end else begin
                            cnt_n = cnt + CW'(1);
                        end
                    end
                    C_DOWN: begin
                        if (cnt == '0) begin
                            st_n  = C_UP;
                            load  = 1'b1;
                            cnt_n = (per_sh == '0) ? '0 : CW'(1);
                        end else begin
                            cnt_n = cnt - CW'(1);
                        end
                    end
                    default: st_n = C_UP;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= C_UP;
            cnt      <= '0;
            per_act  <= '0;
            duty_act <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            if (load) begin
                per_act  <= per_sh;
                duty_act <= duty_sh;
            end
        end
    end

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= per_act);

    p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt) && $stable(per_act));

    p_center_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && center && per_act != '0 && st == C_UP && cnt == per_act)
        |=> st == C_DOWN);

    p_shadow_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !center && per_act != '0 && cnt < per_act)
        |=> $stable(per_act) && $stable(duty_act));

endmodule

// File: rtl/pwm_dt.sv
module pwm_dt
    import pwm_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          target,
    input  logic [DW-1:0] delay,
    output logic          out
);

    dt_st_t        st, st_n;
    logic [DW-1:0] wcnt, wcnt_n;

    always_comb begin
        st_n   = st;
        wcnt_n = wcnt;
        unique case (st)
            D_LOW: begin
                if (target) begin
                    if (delay == '0) begin
                        st_n = D_HIGH;
                    end else begin
                        st_n   = D_WAIT;
                        wcnt_n = delay;
                    end
                end
            end
            D_WAIT: begin
                if (!target) begin
                    st_n = D_LOW;
                end else if (tick) begin
                    if (wcnt == DW'(1)) begin
                        st_n = D_HIGH;
                    end else begin
                        wcnt_n = wcnt - DW'(1);
                    end
                end
            end
            D_HIGH: begin
                if (!target) begin
                    st_n = D_LOW;
                end
            end
            default: st_n = D_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= D_LOW;
            wcnt <= '0;
        end else begin
            st   <= st_n;
            wcnt <= wcnt_n;
        end
    end

    always_comb begin
        out = (st == D_HIGH);
    end

    p_fall_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !target |=> !out);

    p_no_early_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!out && delay != '0 && st == D_LOW) |=> !out);

endmodule

// File: rtl/pwm_fault.sv
module pwm_fault
    import pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fault_in,
    input  logic       clr,
    input  logic [1:0] fc_hi,
    input  logic [1:0] fc_lo,
    input  logic       in_hi,
    input  logic       in_lo,
    output logic       pwm_hi,
    output logic       pwm_lo,
    output logic       oe_hi,
    output logic       oe_lo,
    output logic       active
);

    flt_st_t st, st_n;

    always_comb begin
        st_n = st;
        unique case (st)
            F_OK:    if (fault_in) st_n = F_TRIP;
            F_TRIP:  if (clr && !fault_in) st_n = F_OK;
            default: st_n = F_OK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= F_OK;
        else        st <= st_n;
    end

    // outputs: the fault input acts without waiting for an edge
    always_comb begin
        active = fault_in || (st == F_TRIP);
        if (active) begin
            oe_hi  = !fc_hi[1];
            pwm_hi = !fc_hi[1] && fc_hi[0];
            oe_lo  = !fc_lo[1];
            pwm_lo = !fc_lo[1] && fc_lo[0];
        end else begin
            oe_hi  = 1'b1;
            pwm_hi = in_hi;
            oe_lo  = 1'b1;
            pwm_lo = in_lo;
        end
    end

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !clr) |=> active);

    p_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_in && fc_lo[1]) |-> !oe_lo);

    p_drive1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_in && fc_hi == 2'b01) |-> (oe_hi && pwm_hi));

endmodule

// File: rtl/pwm_chan_prot.sv
module pwm_chan_prot
    import pwm_pkg::*;
#(
    parameter int CW   = 16,
    parameter int DW   = 12,
    parameter int NSRC = 4,
    parameter int AW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-2:0] tick_div,
    input  logic [CW-1:0]   master_cnt,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [CW-1:0]   wr_data,
    input  logic            fault_in,
    output logic [CW-1:0]   cnt_out,
    output logic            pwm_hi,
    output logic            pwm_lo,
    output logic            oe_hi,
    output logic            oe_lo
);

    localparam int SELW = $clog2(NSRC);
    localparam int CFGW = SELW + 6;
    localparam int B_CEN  = SELW;
    localparam int B_SYNC = SELW + 1;

    localparam logic [AW-1:0] A_CFG  = AW'(0);
    localparam logic [AW-1:0] A_PER  = AW'(1);
    localparam logic [AW-1:0] A_DUTY = AW'(2);
    localparam logic [AW-1:0] A_DHI  = AW'(3);
    localparam logic [AW-1:0] A_DLO  = AW'(4);
    localparam logic [AW-1:0] A_OVR  = AW'(5);
    localparam logic [AW-1:0] A_CLR  = AW'(6);

    logic [CFGW-1:0] cfg_q;
    logic [CW-1:0]   per_sh, duty_sh;
    logic [DW-1:0]   dly_q [2];
    logic [3:0]      ovr_q;

    // register file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            per_sh   <= '0;
            duty_sh  <= '0;
            dly_q[0] <= '0;
            dly_q[1] <= '0;
            ovr_q    <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CFG:   cfg_q    <= wr_data[CFGW-1:0];
                A_PER:   per_sh   <= wr_data;
                A_DUTY:  duty_sh  <= wr_data;
                A_DHI:   dly_q[0] <= wr_data[DW-1:0];
                A_DLO:   dly_q[1] <= wr_data[DW-1:0];
                A_OVR:   ovr_q    <= wr_data[3:0];
                default: ;
            endcase
        end
    end

    logic clr_stb;
    assign clr_stb = wr_en && (wr_addr == A_CLR) && wr_data[0];

    // tick selection: source 0 is every clock
    logic [NSRC-1:0] tick_all;
    logic            tick;
    assign tick_all = {tick_div, 1'b1};
    assign tick     = tick_all[cfg_q[SELW-1:0]];

    logic [CW-1:0] cnt, per_act, duty_act;

    pwm_cnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .center   (cfg_q[B_CEN]),
        .per_sh   (per_sh),
        .duty_sh  (duty_sh),
        .cnt      (cnt),
        .per_act  (per_act),
        .duty_act (duty_act)
    );

    assign cnt_out = cnt;

    // compare against own or master counter
    logic [CW-1:0] cmp_cnt;
    logic          raw;
    assign cmp_cnt = cfg_q[B_SYNC] ? master_cnt : cnt;
    assign raw     = cmp_cnt < duty_act;

    // complementary dead-time pair: index 0 high side, 1 low side
    logic [1:0] dt_tgt, dt_out;
    assign dt_tgt = {!raw, raw};

    for (genvar g = 0; g < 2; g++) begin : g_dt
        pwm_dt #(.DW(DW)) u_dt (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .target (dt_tgt[g]),
            .delay  (dly_q[g]),
            .out    (dt_out[g])
        );
    end

    // override stage
    logic ov_hi, ov_lo;
    assign ov_hi = ovr_q[0] ? ovr_q[1] : dt_out[0];
    assign ov_lo = ovr_q[2] ? ovr_q[3] : dt_out[1];

    logic flt_active;

    pwm_fault u_flt (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_in (fault_in),
        .clr      (clr_stb),
        .fc_hi    (cfg_q[SELW+3:SELW+2]),
        .fc_lo    (cfg_q[SELW+5:SELW+4]),
        .in_hi    (ov_hi),
        .in_lo    (ov_lo),
        .pwm_hi   (pwm_hi),
        .pwm_lo   (pwm_lo),
        .oe_hi    (oe_hi),
        .oe_lo    (oe_lo),
        .active   (flt_active)
    );

    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dt_out[0] && dt_out[1]));

    p_ovr_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q[0] && !flt_active) |-> (pwm_hi == ovr_q[1] && oe_hi));

    p_ovr_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q[2] && !flt_active) |-> (pwm_lo == ovr_q[3] && oe_lo));

    p_enable_no_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_active |-> (oe_hi && oe_lo));

endmodule

// File: tb/tb_pwm_chan_prot.sv
module tb_pwm_chan_prot;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  tick_div;
    logic [15:0] master_cnt;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic        fault_in;
    logic [15:0] cnt_out;
    logic        pwm_hi, pwm_lo, oe_hi, oe_lo;

    always #5 clk = ~clk;

    pwm_chan_prot dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_div   (tick_div),
        .master_cnt (master_cnt),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .fault_in   (fault_in),
        .cnt_out    (cnt_out),
        .pwm_hi     (pwm_hi),
        .pwm_lo     (pwm_lo),
        .oe_hi      (oe_hi),
        .oe_lo      (oe_lo)
    );

    int nchk = 0;
    int nbad = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a[2:0];
        wr_data = d[15:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic period_len(output int n);
        int guard = 0;
        while (cnt_out != 0 && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (cnt_out != 0 && n < 1000);
    endtask

    task automatic count_hl(input int n, output int h, output int l);
        h = 0;
        l = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_hi) h++;
            if (pwm_lo) l++;
        end
    endtask

    function automatic int edge_hi(int p, int d, int r);
        if (d == 0) return 0;
        if (d > p) return p + 1;
        return (d > r) ? d - r : 0;
    endfunction

    function automatic int edge_lo(int p, int d, int r);
        if (d == 0) return p + 1;
        if (d > p) return 0;
        return (p + 1 - d > r) ? p + 1 - d - r : 0;
    endfunction

    function automatic int center_hi(int p, int d);
        int s = 0;
        if (0 < d) s++;
        for (int v = 1; v <= p; v++) if (v < d) s++;
        for (int v = 1; v < p; v++) if (v < d) s++;
        return s;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog all actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        int n, h, l, v, mx, m;
        rst_n      = 1'b0;
        tick_div   = '0;
        master_cnt = '0;
        wr_en      = 1'b0;
        wr_addr    = '0;
        wr_data    = '0;
        fault_in   = 1'b0;
        cyc(3);
        // R1 reset state
        check(cnt_out == 0, "R1 cnt", cnt_out, 0);
        check(pwm_hi == 0 && pwm_lo == 0, "R1 outputs", {pwm_hi, pwm_lo}, 0);
        check(oe_hi == 1 && oe_lo == 1, "R1 enables", {oe_hi, oe_lo}, 3);
        rst_n = 1'b1;

        // R2 / R5 / R7 edge-aligned sweep
        wr(0, 0);
        wr(5, 0);
        for (int pi = 0; pi < 2; pi++) begin
            int p = (pi == 0) ? 4 : 7;
            for (int d = 0; d <= p + 1; d++) begin
                for (int k = 0; k < 2; k++) begin
                    wr(1, p);
                    wr(2, d);
                    wr(3, 2 * k);
                    wr(4, k);
                    cyc(3 * (p + 1) + 6);
                    count_hl(p + 1, h, l);
                    if (k == 0) begin
                        check(h == edge_hi(p, d, 0), "R5 edge hi", h, edge_hi(p, d, 0));
                        check(l == edge_lo(p, d, 0), "R5 edge lo", l, edge_lo(p, d, 0));
                    end else begin
                        check(h == edge_hi(p, d, 2), "R7 delayed hi", h, edge_hi(p, d, 2));
                        check(l == edge_lo(p, d, 1), "R7 delayed lo", l, edge_lo(p, d, 1));
                    end
                end
            end
            period_len(n);
            check(n == p + 1, "R2 period", n, p + 1);
        end

        // R3 center-aligned sweep
        wr(0, 4);
        wr(3, 0);
        wr(4, 0);
        for (int pi = 0; pi < 2; pi++) begin
            int p = (pi == 0) ? 3 : 6;
            for (int d = 0; d <= p + 1; d++) begin
                wr(1, p);
                wr(2, d);
                cyc(8 * p + 6);
                count_hl(2 * p, h, l);
                check(h == center_hi(p, d), "R3 center hi", h, center_hi(p, d));
                check(l == 2 * p - center_hi(p, d), "R3 center lo", l, 2 * p - center_hi(p, d));
            end
            period_len(n);
            check(n == 2 * p, "R3 cycle", n, 2 * p);
        end

        // R6 shadowed period
        wr(0, 0);
        wr(1, 9);
        wr(2, 2);
        cyc(30);
        while (cnt_out != 3) @(negedge clk);
        wr(1, 5);
        mx = cnt_out;
        while (cnt_out != 0) begin
            @(negedge clk);
            if (cnt_out > mx) mx = cnt_out;
        end
        check(mx == 9, "R6 old period kept", mx, 9);
        period_len(n);
        check(n == 6, "R6 new period", n, 6);

        // R4 tick selection
        wr(0, 1);
        cyc(2);
        v = cnt_out;
        cyc(6);
        check(cnt_out == v, "R4 hold", cnt_out, v);
        tick_div = 3'b001;
        @(negedge clk);
        tick_div = 3'b000;
        check(cnt_out == ((v >= 5) ? 0 : v + 1), "R4 one tick", cnt_out, (v >= 5) ? 0 : v + 1);
        wr(0, 2);
        v = cnt_out;
        tick_div = 3'b001;
        cyc(6);
        tick_div = 3'b000;
        check(cnt_out == v, "R4 unselected ignored", cnt_out, v);
        tick_div = 3'b010;
        @(negedge clk);
        tick_div = 3'b000;
        check(cnt_out == ((v >= 5) ? 0 : v + 1), "R4 source 2", cnt_out, (v >= 5) ? 0 : v + 1);

        // R5 master counter compare
        wr(0, 8);
        wr(1, 9);
        wr(2, 5);
        cyc(15);
        for (int i = 0; i < 12; i++) begin
            m = (i * 7) % 12;
            @(negedge clk);
            master_cnt = m[15:0];
            @(negedge clk);
            check(pwm_hi == (m < 5), "R5 sync hi", pwm_hi, m < 5);
            check(pwm_lo == (m >= 5), "R5 sync lo", pwm_lo, m >= 5);
        end

        // R8 override
        wr(0, 0);
        wr(2, 4);
        cyc(25);
        wr(5, 3);
        count_hl(10, h, l);
        check(h == 10, "R8 hi forced 1", h, 10);
        wr(5, 5);
        count_hl(10, h, l);
        check(h == 0 && l == 0, "R8 both forced 0", h + l, 0);
        wr(5, 0);
        cyc(3);
        count_hl(10, h, l);
        check(h == 4 && l == 6, "R8 released", h * 100 + l, 406);

        // R9 / R10 fault with override active
        wr(5, 3);
        wr(0, 'h80);
        @(negedge clk);
        fault_in = 1'b1;
        #1;
        check(pwm_hi == 0 && oe_hi == 1, "R9 drive0 over override", {oe_hi, pwm_hi}, 2);
        check(oe_lo == 0, "R9 hi-z", oe_lo, 0);
        @(negedge clk);
        fault_in = 1'b0;
        #1;
        check(oe_lo == 0 && pwm_hi == 0, "R10 latched", {oe_lo, pwm_hi}, 0);
        cyc(5);
        check(oe_lo == 0 && pwm_hi == 0, "R10 still latched", {oe_lo, pwm_hi}, 0);
        fault_in = 1'b1;
        wr(6, 1);
        fault_in = 1'b0;
        cyc(2);
        check(oe_lo == 0, "R10 clear ignored while fault high", oe_lo, 0);
        wr(6, 1);
        check(oe_lo == 1 && pwm_hi == 1, "R10 cleared", {oe_lo, pwm_hi}, 3);

        wr(5, 5);
        wr(0, 'h50);
        @(negedge clk);
        fault_in = 1'b1;
        #1;
        check(pwm_hi == 1 && pwm_lo == 1 && oe_hi == 1 && oe_lo == 1, "R9 drive1",
              {pwm_hi, pwm_lo, oe_hi, oe_lo}, 15);
        @(negedge clk);
        fault_in = 1'b0;
        wr(6, 1);
        check(pwm_hi == 0 && pwm_lo == 0, "R10 back to override", {pwm_hi, pwm_lo}, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule